// File: doc/BRIEF.md
# ALU status flags register

This block holds the eight-bit processor status byte and the logic that updates it after each ALU operation. On a cycle with `op_valid` high, it reads the ALU result, the operation class and the carry, half-carry and overflow signals from the datapath. It then updates only the flags that this class of operation affects. The byte also holds three control bits:

- a bit that records whether the last arithmetic step was an addition or a subtraction, which a later decimal-adjust step uses;
- a fast-interrupt status bit, which blocks interrupts and turns an interrupt return into the fast-return sequence;
- a bit that selects which register bank serves addresses 224 to 255.

Instruction decode drives the strobes for fast-interrupt entry, interrupt return, bank selection and software writes of the byte. The four testable conditions go to the branch logic on ports of their own.

Top module: `status_flags`

## Requirements
- R1: The flag byte is laid out as Carry bit 7, Zero bit 6, Sign bit 5, Overflow bit 4, Decimal-adjust bit 3, Half-carry bit 2, Fast-interrupt bit 1 and Bank bit 0. The `op_kind` codes are 0 add, 1 subtract, 2 logical, 3 rotate/shift and 4 bit test. Codes 5 to 7 change no flag.
- R2: On every valid operation of codes 0 to 4, Zero becomes 1 exactly when `alu_res` is zero.
- R3: Add and subtract load Carry from `alu_c`, Overflow from `alu_v`, Half-carry from `alu_h` and Sign from `alu_res[7]`.
- R4: A logical operation updates Zero and Sign and clears Overflow. It leaves Carry, Decimal-adjust and Half-carry unchanged.
- R5: Decimal-adjust becomes 0 after an add and 1 after a subtract. No other operation class changes it.
- R6: A rotate/shift operation loads Carry from `alu_c`, Overflow from `alu_v`, and Zero and Sign from the result. It leaves Decimal-adjust and Half-carry unchanged.
- R7: A bit-test operation changes only Zero.
- R8: `fi_enter` sets the Fast-interrupt bit, and `iret` clears it. Entry wins if both are high in the same cycle. `irq_inhibit` is high while the bit is set. `fast_ret` is high combinationally when `iret` is high and the bit is set.
- R9: `sel_bank1` sets the Bank bit and `sel_bank0` clears it. If both are high, the bit is set. `bank` reflects the bit.
- R10: `wr_en` loads bits 7 to 2 from `wr_data` and never touches bits 1 and 0. A write in a cycle with `op_valid` high is discarded.
- R11: `cond_c`, `cond_z`, `cond_s` and `cond_v` equal Carry, Zero, Sign and Overflow.
- R12: A synchronous active-high `rst` clears all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | ALU result valid this cycle |
| op_kind | input | 3 | Operation class code |
| alu_res | input | 8 | ALU result |
| alu_c | input | 1 | Carry/borrow out of bit 7, or shifted-out bit |
| alu_h | input | 1 | Half-carry/borrow |
| alu_v | input | 1 | Two's-complement overflow |
| fi_enter | input | 1 | Fast-interrupt entry strobe |
| iret | input | 1 | Interrupt-return fetch strobe |
| sel_bank0 | input | 1 | Select bank 0 |
| sel_bank1 | input | 1 | Select bank 1 |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write data |
| flags | output | 8 | Packed flag byte |
| cond_c | output | 1 | Carry condition |
| cond_z | output | 1 | Zero condition |
| cond_s | output | 1 | Sign condition |
| cond_v | output | 1 | Overflow condition |
| irq_inhibit | output | 1 | Interrupts blocked |
| fast_ret | output | 1 | Interrupt return takes the fast path |
| bank | output | 1 | Current register bank |

## Verification
The hardest thing to show from the ports is that a flag was left alone: each operation class preserves some bits, and a bit that happens to hold 0 already cannot reveal a missed update. Each table vector therefore first writes a chosen preset into bits 7 to 2 through the software write port, so that the preserved bits hold values that differ from what a wrong update would produce. The write-versus-operation collision and the fast-return path are reached by driving the two strobes in the same cycle. The combinational `fast_ret` output is sampled before the clock edge that clears the Fast-interrupt bit.

// File: rtl/status_flags.sv
module status_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_kind,
  input  logic [W-1:0] alu_res,
  input  logic         alu_c,
  input  logic         alu_h,
  input  logic         alu_v,
  input  logic         fi_enter,
  input  logic         iret,
  input  logic         sel_bank0,
  input  logic         sel_bank1,
  input  logic         wr_en,
  input  logic [7:0]   wr_data,
  output logic [7:0]   flags,
  output logic         cond_c,
  output logic         cond_z,
  output logic         cond_s,
  output logic         cond_v,
  output logic         irq_inhibit,
  output logic         fast_ret,
  output logic         bank
);
  localparam logic [2:0] K_ADD = 3'd0, K_SUB = 3'd1, K_LOG = 3'd2,
                         K_SHF = 3'd3, K_TST = 3'd4;

  logic c_q, z_q, s_q, v_q, d_q, h_q, f_q, b_q;
  logic zero_res, msb_res, known;

  assign zero_res = (alu_res == '0);
  assign msb_res  = alu_res[W-1];
  assign known    = (op_kind <= K_TST);

  always_ff @(posedge clk) begin
    if (rst) begin
      {c_q, z_q, s_q, v_q, d_q, h_q, f_q, b_q} <= '0;
    end else begin
      if (op_valid && known) begin
        z_q <= zero_res;
        if (op_kind != K_TST) s_q <= msb_res;
        case (op_kind)
          K_ADD, K_SUB: begin
            c_q <= alu_c;
            v_q <= alu_v;
            h_q <= alu_h;
            d_q <= (op_kind == K_SUB);
          end
          K_LOG: v_q <= 1'b0;
          K_SHF: begin
            c_q <= alu_c;
            v_q <= alu_v;
          end
          default: ;
        endcase
      end else if (wr_en && !op_valid) begin
        {c_q, z_q, s_q, v_q, d_q, h_q} <= wr_data[7:2];
      end
      if (fi_enter)  f_q <= 1'b1;
      else if (iret) f_q <= 1'b0;
      if (sel_bank1)      b_q <= 1'b1;
      else if (sel_bank0) b_q <= 1'b0;
    end
  end

  assign flags       = {c_q, z_q, s_q, v_q, d_q, h_q, f_q, b_q};
  assign cond_c      = c_q;
  assign cond_z      = z_q;
  assign cond_s      = s_q;
  assign cond_v      = v_q;
  assign irq_inhibit = f_q;
  assign fast_ret    = iret & f_q;
  assign bank        = b_q;
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [2:0] op_kind,
  input logic [7:0] alu_res,
  input logic       alu_c,
  input logic       fi_enter,
  input logic       iret,
  input logic       sel_bank0,
  input logic       sel_bank1,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] flags,
  input logic       irq_inhibit,
  input logic       fast_ret,
  input logic       bank
);
  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind <= 3'd4) |=> (flags[6] == ($past(alu_res) == 8'h00)));
  p_arith_c_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind <= 3'd1) |=> (flags[7] == $past(alu_c)));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd2) |=> !flags[4]);
  p_logic_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd2) |=> $stable(flags[7]) && $stable(flags[3:2]));
  p_sub_dflag_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd1) |=> flags[3]);
  p_test_only_z_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 3'd4 && !wr_en) |=> $stable(flags[7]) && $stable(flags[5:2]));
  p_fi_enter_r8: assert property (@(posedge clk) disable iff (rst)
    fi_enter |=> irq_inhibit);
  p_fast_ret_r8: assert property (@(posedge clk) disable iff (rst)
    fast_ret |-> (iret && flags[1]));
  p_bank1_r9: assert property (@(posedge clk) disable iff (rst)
    sel_bank1 |=> bank);
  p_bank0_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_bank0 && !sel_bank1) |=> !bank);
  p_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !op_valid) |=> (flags[7:2] == $past(wr_data[7:2])));
  p_reset_r12: assert property (@(posedge clk)
    rst |=> (flags == 8'h00));
endmodule

bind status_flags status_flags_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
  .alu_res(alu_res), .alu_c(alu_c), .fi_enter(fi_enter), .iret(iret),
  .sel_bank0(sel_bank0), .sel_bank1(sel_bank1), .wr_en(wr_en),
  .wr_data(wr_data), .flags(flags), .irq_inhibit(irq_inhibit),
  .fast_ret(fast_ret), .bank(bank)
);

// File: tb/sim_status_flags.sv
module sim_status_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {preset[7:0], kind[2:0], res[7:0], c, h, v, expected[7:0]}
  localparam logic [29:0] VEC [NV] = '{
    {8'h00, 3'd0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hC4},
    {8'h00, 3'd1, 8'h80, 1'b0, 1'b1, 1'b1, 8'h3C},
    {8'hFC, 3'd2, 8'h00, 1'b0, 1'b0, 1'b1, 8'hCC},
    {8'h00, 3'd2, 8'h90, 1'b1, 1'b1, 1'b1, 8'h20},
    {8'h0C, 3'd3, 8'h01, 1'b1, 1'b0, 1'b1, 8'h9C},
    {8'hB0, 3'd4, 8'h00, 1'b0, 1'b1, 1'b0, 8'hF0},
    {8'h40, 3'd4, 8'h04, 1'b1, 1'b1, 1'b1, 8'h00},
    {8'h08, 3'd0, 8'h7F, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 3'd5, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00},
    {8'h54, 3'd1, 8'hFF, 1'b1, 1'b0, 1'b0, 8'hA8}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic op_valid = 1'b0, alu_c = 1'b0, alu_h = 1'b0, alu_v = 1'b0;
  logic [2:0] op_kind = '0;
  logic [7:0] alu_res = '0, wr_data = '0;
  logic fi_enter = 1'b0, iret = 1'b0, sel_bank0 = 1'b0, sel_bank1 = 1'b0, wr_en = 1'b0;
  logic [7:0] flags;
  logic cond_c, cond_z, cond_s, cond_v, irq_inhibit, fast_ret, bank;
  int tests = 0, fails = 0;

  status_flags u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; wr_en = 0; fi_enter = 0; iret = 0; sel_bank0 = 0; sel_bank1 = 0; rst = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R12 reset", flags, 8'h00);
    idle();

    for (int i = 0; i < NV; i++) begin
      wr_en = 1; wr_data = VEC[i][29:22];
      tick();
      op_valid = 1; op_kind = VEC[i][21:19]; alu_res = VEC[i][18:11];
      {alu_c, alu_h, alu_v} = VEC[i][10:8];
      tick();
      chk($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", i), flags, VEC[i][7:0]);
    end

    chk("R11 cond", {4'h0, cond_c, cond_z, cond_s, cond_v}, 8'h0A);

    wr_en = 1; wr_data = 8'h00; tick();
    wr_en = 1; wr_data = 8'hFC; op_valid = 1; op_kind = 3'd2; alu_res = 8'h01; tick();
    chk("R10 write dropped on op", flags, 8'h00);

    fi_enter = 1; tick();
    chk("R8 fi set", {6'h0, irq_inhibit, flags[1]}, 8'h03);
    sel_bank1 = 1; sel_bank0 = 1; tick();
    chk("R9 both selects", {7'h0, bank}, 8'h01);
    wr_en = 1; wr_data = 8'h00; tick();
    chk("R10 write keeps bits 1:0", flags, 8'h03);
    wr_en = 1; wr_data = 8'hF0; tick();
    chk("R11 cond after write", {4'h0, cond_c, cond_z, cond_s, cond_v}, 8'h0F);

    iret = 1; #1;
    chk("R8 fast_ret high", {7'h0, fast_ret}, 8'h01);
    tick();
    chk("R8 iret clears", {6'h0, irq_inhibit, flags[1]}, 8'h00);
    iret = 1; #1;
    chk("R8 fast_ret low", {7'h0, fast_ret}, 8'h00);
    tick();

    sel_bank0 = 1; tick();
    chk("R9 bank0", {7'h0, bank}, 8'h00);
    sel_bank1 = 1; tick();
    chk("R9 bank1", flags, 8'hF1);

    rst = 1; tick();
    chk("R12 mid-run reset", flags, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule